// File: doc/BRIEF.md
# Watchdog Timer with Boot-Locked Control

This block is a watchdog timer clocked straight from the crystal clock. It has an 8-bit control register with the following fields:

- a 3-bit timeout code;
- an enable that lets the watchdog keep running while the core is halted;
- a flag that blocks the low-power stop state;
- three reserved bits.

After a reset, every writable field is held at a safe default: the longest timeout, counting through halt, and stop blocked. Firmware can change these fields only during one short window. That window is the first instruction the core executes after reset. The core marks each instruction boundary with a strobe, and the block uses that strobe to bound the window.

Once the window closes, the control fields stay fixed until the next reset. After that point, a runaway program can neither disable the watchdog nor make it slower. During normal operation, software pats the watchdog with a refresh strobe. If it fails to do so within the selected period, the block raises a one-cycle reset request.

Top module: `wdt_boot_lock`

## Requirements
- R1: After reset the control register reads 0xF8, which means bit 7 = 1, code (bits 6:4) = 111 and bit 3 = 1. The reset request output is low.
- R2: The writable bits 7:3 are written only in the window. The window opens on the first instruction strobe after reset and closes on the second. A write is accepted on a clock edge only while the window is open. Writes made before the window opens, or after it closes, leave the register unchanged until the next reset.
- R3: Bits 2:0 always read 0, whatever value is written to them.
- R4: A nonzero code k (1 to 7) sets the timeout T = 2^(BASE_W+k-1) clock cycles, so each step up doubles the period. The request is asserted after exactly T counting cycles since the counter was last cleared, and not one cycle earlier.
- R5: The request lasts one cycle. The counter then restarts from zero, so an unrefreshed watchdog issues a new request every T cycles.
- R6: A refresh strobe clears the counter, which restarts the full timeout.
- R7: While halted with bit 7 = 0, the counter holds its value and no request is issued. With bit 7 = 1, halt has no effect on counting.
- R8: Code 000 disables the watchdog, so no request is ever issued.
- R9: An accepted write that changes the timeout code clears the counter.
- R10: The stop-permit output is the inverse of bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_i | input | 1 | Instruction boundary strobe from the core |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read data |
| refresh_i | input | 1 | Watchdog refresh strobe |
| halt_i | input | 1 | Core is in halt |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |
| stop_allow_o | output | 1 | Stop state permitted |

## Verification
The bench builds the block with BASE_W = 3, so the seven timeout codes map to periods from 8 to 512 cycles. With periods this short, every code can be swept exhaustively, and each one is checked at the exact cycle on which its request fires, both for the first timeout and for the periodic repeat. The same short periods also bring the window-lock ordering within reach, together with the halt hold, the clear on a code change and the disabled code, all within a few thousand cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WIN_PRE  = 2'd0,
    WIN_OPEN = 2'd1,
    WIN_LOCK = 2'd2
  } win_state_e;

  localparam logic [4:0] CTRL_HI_RST = 5'b11111;
  localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_i,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             run_halt_o,
  output logic             stop_dis_o,
  output logic             sel_chg_o
);
  win_state_e win_q, win_d;
  logic [4:0] hi_q;
  logic       wr_ok;

  always_comb begin
    win_d = win_q;
    if (insn_i) begin
      case (win_q)
        WIN_PRE:  win_d = WIN_OPEN;
        WIN_OPEN: win_d = WIN_LOCK;
        default:  win_d = WIN_LOCK;
      endcase
    end
  end

  assign wr_ok     = we_i && (win_q == WIN_OPEN);
  assign sel_chg_o = wr_ok && (wdata_i[6:4] != hi_q[3:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= WIN_PRE;
      hi_q  <= CTRL_HI_RST;
    end else begin
      win_q <= win_d;
      if (wr_ok) hi_q <= wdata_i[7:3];
    end
  end

  assign rdata_o    = {hi_q, 3'b000};
  assign run_halt_o = hi_q[4];
  assign sel_o      = hi_q[3:1];
  assign stop_dis_o = hi_q[0];

  // R2
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == WIN_LOCK) |=> $stable(hi_q));
  // R2
  pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == WIN_PRE) |=> $stable(hi_q));
  // R2
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == WIN_LOCK) |=> (win_q == WIN_LOCK));
endmodule

// File: rtl/wdt_term_dec.sv
module wdt_term_dec
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_W = 16,
  localparam int unsigned CNT_W = BASE_W + 6
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o,
  output logic [CNT_W-1:0] term_m1_o
);
  // terminal - 1 is a mask of BASE_W + sel - 1 ones
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      term_m1_o[i] = (sel_i != '0) && (i < (BASE_W + int'(sel_i) - 1));
    end
  end

  assign en_o = (sel_i != '0);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] term_m1_i,
  input  logic             refresh_i,
  input  logic             sel_chg_i,
  input  logic             halt_i,
  input  logic             run_halt_i,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             run;

  assign run = !halt_i || run_halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (refresh_i || sel_chg_i || !en_i) begin
        cnt_q <= '0;
      end else if (run) begin
        if (cnt_q == term_m1_i) begin
          cnt_q <= '0;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;

  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  // R6
  refresh_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (cnt_q == '0));
  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !run_halt_i && en_i && !refresh_i && !sel_chg_i)
      |=> ($stable(cnt_q) && !req_q));
  // R8
  off_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_q);
  // R9
  sel_chg_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_boot_lock.sv
module wdt_boot_lock
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       insn_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic [7:0] ctrl_rdata_o,
  input  logic       refresh_i,
  input  logic       halt_i,
  output logic       wdt_rst_o,
  output logic       stop_allow_o
);
  localparam int unsigned CNT_W = BASE_W + 6;

  logic [SEL_W-1:0] sel;
  logic             run_halt, stop_dis, sel_chg, en;
  logic [CNT_W-1:0] term_m1;

  wdt_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .insn_i     (insn_i),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .rdata_o    (ctrl_rdata_o),
    .sel_o      (sel),
    .run_halt_o (run_halt),
    .stop_dis_o (stop_dis),
    .sel_chg_o  (sel_chg)
  );

  wdt_term_dec #(.BASE_W(BASE_W)) u_dec (
    .sel_i     (sel),
    .en_o      (en),
    .term_m1_o (term_m1)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .term_m1_i  (term_m1),
    .refresh_i  (refresh_i),
    .sel_chg_i  (sel_chg),
    .halt_i     (halt_i),
    .run_halt_i (run_halt),
    .req_o      (wdt_rst_o)
  );

  assign stop_allow_o = !stop_dis;

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_rdata_o[2:0] == 3'b000));
endmodule

// File: tb/tb_wdt_boot_lock.sv
`timescale 1ns/1ps
module tb_wdt_boot_lock;
  localparam int unsigned BASE_W = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       insn_i = 1'b0, ctrl_we_i = 1'b0, refresh_i = 1'b0, halt_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [7:0] ctrl_rdata_o;
  logic       wdt_rst_o, stop_allow_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  wdt_boot_lock #(.BASE_W(BASE_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .insn_i(insn_i), .ctrl_we_i(ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
    .refresh_i(refresh_i), .halt_i(halt_i), .wdt_rst_o(wdt_rst_o),
    .stop_allow_o(stop_allow_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; insn_i = 0; ctrl_we_i = 0; refresh_i = 0; halt_i = 0;
    step(2);
    rst_ni = 1'b1;
  endtask

  task automatic insn();
    insn_i = 1'b1; step(1); insn_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v; step(1); ctrl_we_i = 1'b0;
  endtask

  task automatic refresh();
    refresh_i = 1'b1; step(1); refresh_i = 1'b0;
  endtask

  task automatic setup(input logic [7:0] v);
    do_reset(); insn(); wr(v); insn();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    do_reset();
    // R1 reset state
    chk("R1 rdata", ctrl_rdata_o, 8'hF8);
    chk("R1 req", wdt_rst_o, 0);
    chk("R10 stop_allow at reset", stop_allow_o, 0);

    // R2 write before window ignored
    wr(8'h08);
    chk("R2 pre-window write", ctrl_rdata_o, 8'hF8);
    insn();
    wr(8'h9F);
    chk("R2 in-window write", ctrl_rdata_o, 8'h98);
    chk("R3 reserved bits zero", ctrl_rdata_o[2:0], 0);
    chk("R10 stop_allow bit3=1", stop_allow_o, 0);
    wr(8'h37);
    chk("R2 second in-window write", ctrl_rdata_o, 8'h30);
    chk("R10 stop_allow bit3=0", stop_allow_o, 1);
    insn();
    wr(8'hF8);
    chk("R2 post-window write", ctrl_rdata_o, 8'h30);
    insn(); insn();
    wr(8'hC8);
    chk("R2 window stays closed", ctrl_rdata_o, 8'h30);

    // R4/R5 sweep every nonzero code
    for (int k = 1; k < 8; k++) begin
      int t;
      t = 1 << (BASE_W + k - 1);
      setup({1'b1, 3'(k), 4'b1000});
      refresh();
      step(t - 1);
      chk($sformatf("R4 code %0d early", k), wdt_rst_o, 0);
      step(1);
      chk($sformatf("R4 code %0d at T", k), wdt_rst_o, 1);
      step(1);
      chk($sformatf("R5 code %0d pulse end", k), wdt_rst_o, 0);
      step(t - 2);
      chk($sformatf("R5 code %0d repeat early", k), wdt_rst_o, 0);
      step(1);
      chk($sformatf("R5 code %0d repeat", k), wdt_rst_o, 1);
    end

    // R8 code 000 disables
    setup(8'h88);
    cnt = 0;
    for (int i = 0; i < 1200; i++) begin
      step(1);
      if (wdt_rst_o) cnt++;
    end
    chk("R8 no request when disabled", cnt, 0);

    // R6 refresh restarts
    setup(8'h98);
    refresh();
    step(5);
    refresh();
    step(7);
    chk("R6 no request after refresh", wdt_rst_o, 0);
    step(1);
    chk("R6 request T after refresh", wdt_rst_o, 1);

    // R7 halt hold with bit7=0
    setup(8'h18);
    refresh();
    step(3);
    halt_i = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (wdt_rst_o) cnt++;
    end
    chk("R7 no request during halt", cnt, 0);
    halt_i = 1'b0;
    step(4);
    chk("R7 held count early", wdt_rst_o, 0);
    step(1);
    chk("R7 held count resumes", wdt_rst_o, 1);

    // R7 bit7=1 counts through halt
    setup(8'h98);
    refresh();
    halt_i = 1'b1;
    step(7);
    chk("R7 run in halt early", wdt_rst_o, 0);
    step(1);
    chk("R7 run in halt fires", wdt_rst_o, 1);
    halt_i = 1'b0;

    // R9 code change clears counter
    do_reset();
    step(6);
    insn();
    wr(8'h98);
    step(7);
    chk("R9 cleared on code change early", wdt_rst_o, 0);
    step(1);
    chk("R9 cleared on code change fires", wdt_rst_o, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule